// File: doc/BRIEF.md
# Four-Port Configurable GPIO Controller

This block manages four pin ports for a small microcontroller. Ports A, B and C have eight pins each and port D has three. Software uses a byte-wide register bus to set three things for each port: the pin direction, the drive style and the output data. The same bus returns the live pad levels. The block does not drive pads itself. For every pin it produces a registered pad-enable, a pad-output value and a fast-slew flag, and the pad ring acts on these.

A pin on ports A to C drives when its direction bit is set or when an external per-pin enable from neighbouring programmable logic is active. When that enable is low, the direction bit alone decides. Port D takes its direction from its register only.

The meaning of a drive bit depends on the port and the bit. On some pins it selects open-drain. In open-drain mode the pin pulls low for a data 0 and releases the pad for a data 1. On other pins it selects fast slew.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A direction bit of 1 makes its pin an output and a bit of 0 makes it an input. A push-pull output pin has pad_oe high. A pin that is an input with no external enable has pad_oe low.
- R2: After reset all direction, data-out and drive registers read 0, and all pad_oe, pad_out and pad_fast bits are 0.
- R3: On ports A, B and C a pin is an output when its direction bit or its ext_oe bit is 1. Bit 8*p+i of ext_oe belongs to port p (A=0, B=1, C=2), pin i. A change on ext_oe appears on pad_oe after the next rising clock edge.
- R4: Port D has no external enable, so its pins drive only when their direction bit is 1.
- R5: Port D implements bits 2:0 only. Writes to bits 7:3 of its registers are dropped and read back as 0, and bits 31:27 of pad_oe, pad_out and pad_fast stay 0.
- R6: Drive bit roles: on ports A and B, bits 7:4 select open-drain and bits 3:0 select slew. On port C all eight bits select open-drain. On port D bits 2:0 select slew.
- R7: A push-pull pin (drive bit 0, or a slew-role bit) puts its data bit on pad_out. An open-drain pin (drive bit 1 on an open-drain-role bit) has pad_out 0. If it is an output, it has pad_oe 1 when its data is 0 and pad_oe 0 when its data is 1.
- R8: pad_fast is 1 exactly on slew-role bits whose drive bit is 1. On open-drain-role bits pad_fast is 0.
- R9: Address map: bus_addr[3:2] selects the port (0=A, 1=B, 2=C, 3=D). bus_addr[1:0] selects the register: 0 data-in, 1 data-out, 2 direction, 3 drive. bus_rdata is combinational from bus_addr.
- R10: A read of data-in returns the present pad_in bits of the port, masked to the implemented pins, whatever the direction. A write to the data-in address changes no register and no pad signal.
- R11: A write happens on the rising edge at which bus_wr is 1. The register and the pad signals it affects change at that same edge. With bus_wr at 0, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Port and register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pad_in | input | 32 | Pad input levels, 8 per port, port D in bits 26:24 |
| ext_oe | input | 24 | External output enables for ports A, B and C |
| pad_oe | output | 32 | Registered pad driver enable |
| pad_out | output | 32 | Registered pad output value |
| pad_fast | output | 32 | Registered fast-slew select |

## Verification
For each port, the bench sweeps all 256 direction values. Each value is paired with data, drive and external-enable patterns derived arithmetically from it. This separates the direction-OR-enable rule from the open-drain release rule and the slew-role mapping, bit by bit and port by port. Directed cases cover the rest:
- one-edge lag of ext_oe and the absence of any enable on port D;
- clipping of port D's upper bits;
- data-in reads under mixed directions;
- ignored writes to the data-in address and writes with the strobe low;
- a full address-map walk with distinct values, to catch crossed registers.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO port controller.
// Holds pin width, port count, register select codes and per-port role masks.
package gpio_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 4;
    localparam int PSEL_W    = $clog2(NUM_PORTS);
    localparam int RSEL_W    = 2;
    localparam int ADDR_W    = PSEL_W + RSEL_W;

    typedef enum logic [RSEL_W-1:0] {
        REG_DIN  = 2'd0,
        REG_DOUT = 2'd1,
        REG_DIR  = 2'd2,
        REG_DRV  = 2'd3
    } reg_sel_e;

    // Implemented pins of a port: the last port has three pins.
    function automatic logic [PORT_W-1:0] impl_mask(input int p);
        return (p == NUM_PORTS - 1) ? 8'h07 : 8'hFF;
    endfunction

    // Drive bits that select open-drain.
    function automatic logic [PORT_W-1:0] od_mask(input int p);
        case (p)
            0, 1:    return 8'hF0;
            2:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // Drive bits that select fast slew.
    function automatic logic [PORT_W-1:0] slew_mask(input int p);
        case (p)
            0, 1:    return 8'h0F;
            2:       return 8'h00;
            default: return 8'h07;
        endcase
    endfunction
endpackage

// File: rtl/gpio_pad_resolve.sv
// Combinational per-port pad resolution.
// Turns direction, external enable, data and drive bits into pad-enable,
// pad-output and fast-slew values. Assumes inputs are already masked to the
// implemented pins; HAS_OE = 0 ignores the external enable.
module gpio_pad_resolve
    import gpio_pkg::*;
#(
    parameter bit                HAS_OE    = 1'b1,
    parameter logic [PORT_W-1:0] OD_MASK   = '0,
    parameter logic [PORT_W-1:0] SLEW_MASK = '0
) (
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] ext_en,
    input  logic [PORT_W-1:0] data,
    input  logic [PORT_W-1:0] drv,
    output logic [PORT_W-1:0] oe,
    output logic [PORT_W-1:0] out,
    output logic [PORT_W-1:0] fast
);
    localparam logic [PORT_W-1:0] EN_KEEP = HAS_OE ? '1 : '0;

    logic [PORT_W-1:0] od_sel;
    logic [PORT_W-1:0] as_output;

    // Resolve output state, open-drain release and slew per pin.
    always_comb begin
        od_sel    = drv & OD_MASK;
        as_output = dir | (ext_en & EN_KEEP);
        oe        = as_output & ~(od_sel & data);
        out       = data & ~od_sel;
        fast      = drv & SLEW_MASK;
    end
endmodule

// File: rtl/gpio_port.sv
// One GPIO port: data-out, direction and drive registers, readback mux,
// and registered pad controls.
// Pad controls are computed from the next register state, so they change on
// the same edge as a write. Writes are masked to IMPL_MASK.
module gpio_port
    import gpio_pkg::*;
#(
    parameter bit                HAS_OE    = 1'b1,
    parameter logic [PORT_W-1:0] IMPL_MASK = '1,
    parameter logic [PORT_W-1:0] OD_MASK   = '0,
    parameter logic [PORT_W-1:0] SLEW_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RSEL_W-1:0] reg_sel,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] ext_en,
    output logic [PORT_W-1:0] rdata,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_fast
);
    logic [PORT_W-1:0] data_q, dir_q, drv_q;
    logic [PORT_W-1:0] data_d, dir_d, drv_d;
    logic [PORT_W-1:0] oe_d, out_d, fast_d;

    // Next register state from a bus write.
    always_comb begin
        data_d = data_q;
        dir_d  = dir_q;
        drv_d  = drv_q;
        if (wr_en) begin
            case (reg_sel_e'(reg_sel))
                REG_DOUT: data_d = wdata & IMPL_MASK;
                REG_DIR:  dir_d  = wdata & IMPL_MASK;
                REG_DRV:  drv_d  = wdata & IMPL_MASK;
                default:  ;
            endcase
        end
    end

    gpio_pad_resolve #(
        .HAS_OE    (HAS_OE),
        .OD_MASK   (OD_MASK & IMPL_MASK),
        .SLEW_MASK (SLEW_MASK & IMPL_MASK)
    ) resolve_i (
        .dir    (dir_d),
        .ext_en (ext_en & IMPL_MASK),
        .data   (data_d),
        .drv    (drv_d),
        .oe     (oe_d),
        .out    (out_d),
        .fast   (fast_d)
    );

    // Register state and pad controls together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            dir_q    <= '0;
            drv_q    <= '0;
            pad_oe   <= '0;
            pad_out  <= '0;
            pad_fast <= '0;
        end else begin
            data_q   <= data_d;
            dir_q    <= dir_d;
            drv_q    <= drv_d;
            pad_oe   <= oe_d;
            pad_out  <= out_d;
            pad_fast <= fast_d;
        end
    end

    // Readback of the selected register or the live pins.
    always_comb begin
        case (reg_sel_e'(reg_sel))
            REG_DIN:  rdata = pin_in & IMPL_MASK;
            REG_DOUT: rdata = data_q;
            REG_DIR:  rdata = dir_q;
            default:  rdata = drv_q;
        endcase
    end

    // R2: pads idle right after reset
    a_r2_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_fast == '0));

    // R1: a push-pull pin with direction 1 is driving
    a_r1_dir_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & ~(drv_q & OD_MASK) & ~pad_oe) == '0);

    // R7: open-drain pin with data 1 is released
    a_r7_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & drv_q & OD_MASK & data_q) == '0);

    // R7: open-drain pin never outputs a 1
    a_r7_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & drv_q & OD_MASK) == '0);

    // R11: registers hold without a write
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(data_q) && $stable(dir_q) && $stable(drv_q)));

    generate
        if (!HAS_OE) begin : g_no_ext
            // R4: without external enable only direction drives
            a_r4_dir_only: assert property (@(posedge clk) disable iff (!rst_n)
                (pad_oe & ~dir_q) == '0);
        end
    endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
// Top of the four-port GPIO controller.
// Decodes the byte-wide register bus into per-port write enables, muxes read
// data, and packs the per-port pad controls. The last port has no external
// enable input; its enable is tied low.
module gpio_port_ctrl
    import gpio_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [PORT_W-1:0]             bus_wdata,
    output logic [PORT_W-1:0]             bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0]   pad_in,
    input  logic [(NUM_PORTS-1)*PORT_W-1:0] ext_oe,
    output logic [NUM_PORTS*PORT_W-1:0]   pad_oe,
    output logic [NUM_PORTS*PORT_W-1:0]   pad_out,
    output logic [NUM_PORTS*PORT_W-1:0]   pad_fast
);
    logic [PSEL_W-1:0] port_sel;
    logic [RSEL_W-1:0] reg_sel;
    logic [PORT_W-1:0] port_rdata [NUM_PORTS];

    assign port_sel = bus_addr[ADDR_W-1:RSEL_W];
    assign reg_sel  = bus_addr[RSEL_W-1:0];

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port
            logic [PORT_W-1:0] en_p;
            if (p < NUM_PORTS - 1) begin : g_ext
                assign en_p = ext_oe[p*PORT_W +: PORT_W];
            end else begin : g_none
                assign en_p = '0;
            end

            gpio_port #(
                .HAS_OE    (p < NUM_PORTS - 1),
                .IMPL_MASK (impl_mask(p)),
                .OD_MASK   (od_mask(p)),
                .SLEW_MASK (slew_mask(p))
            ) port_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (bus_wr && (port_sel == PSEL_W'(p))),
                .reg_sel  (reg_sel),
                .wdata    (bus_wdata),
                .pin_in   (pad_in[p*PORT_W +: PORT_W]),
                .ext_en   (en_p),
                .rdata    (port_rdata[p]),
                .pad_oe   (pad_oe[p*PORT_W +: PORT_W]),
                .pad_out  (pad_out[p*PORT_W +: PORT_W]),
                .pad_fast (pad_fast[p*PORT_W +: PORT_W])
            );
        end
    endgenerate

    // Select read data of the addressed port.
    always_comb bus_rdata = port_rdata[port_sel];

    // R5: unimplemented pins of the last port stay quiet
    a_r5_d_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[NUM_PORTS*PORT_W-1 -: 5] | pad_out[NUM_PORTS*PORT_W-1 -: 5]
         | pad_fast[NUM_PORTS*PORT_W-1 -: 5]) == '0);
endmodule

// File: tb/gpio_port_ctrl_tb.sv
// Self-checking bench: per-port sweep of 256 direction values plus directed cases.
module gpio_port_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pad_in = '0;
    logic [23:0] ext_oe = '0;
    logic [31:0] pad_oe, pad_out, pad_fast;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .ext_oe(ext_oe), .pad_oe(pad_oe), .pad_out(pad_out), .pad_fast(pad_fast)
    );

    // Bench-side masks from R5 and R6.
    function automatic logic [7:0] m_impl(int p); return (p == 3) ? 8'h07 : 8'hFF; endfunction
    function automatic logic [7:0] m_od(int p);
        return (p < 2) ? 8'hF0 : (p == 2) ? 8'hFF : 8'h00;
    endfunction
    function automatic logic [7:0] m_slew(int p);
        return (p < 2) ? 8'h0F : (p == 2) ? 8'h00 : 8'h07;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int p, int r, logic [7:0] d);
        @(negedge clk);
        bus_addr = 4'((p << 2) | r);
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int p, int r, output logic [7:0] d);
        bus_addr = 4'((p << 2) | r);
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        for (int p = 0; p < 4; p++)
            for (int r = 1; r < 4; r++) begin
                rd(p, r, rv);
                chk("R2 reg reset", rv, 8'h00);
            end
        chk("R2 pad_oe reset", 8'(|pad_oe), 8'h00);
        chk("R2 pad_out reset", 8'(|pad_out), 8'h00);
        chk("R2 pad_fast reset", 8'(|pad_fast), 8'h00);

        // R1 R3 R4 R6 R7 R8: sweep every direction value on every port
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] dir, dat, drv, oe, od, en, eo, eout, ef;
                string tg;
                dir = 8'(v);
                dat = 8'(v) ^ 8'hA5;
                drv = 8'(v * 13 + 7);
                oe  = 8'(v * 37 + 11);
                if (p < 3) ext_oe[p*8 +: 8] = oe;
                wr(p, 1, dat);
                wr(p, 3, drv);
                wr(p, 2, dir);
                dir = dir & m_impl(p);
                dat = dat & m_impl(p);
                drv = drv & m_impl(p);
                od  = drv & m_od(p);
                en  = dir | ((p < 3) ? oe : 8'h00);
                eo  = en & ~(od & dat);
                eout = dat & ~od;
                ef  = drv & m_slew(p);
                tg = (p == 3) ? "R4/R5" : "R1/R3";
                chk({tg, " pad_oe sweep"}, pad_oe[p*8 +: 8], eo);
                chk("R7 pad_out sweep", pad_out[p*8 +: 8], eout);
                chk("R6/R8 pad_fast sweep", pad_fast[p*8 +: 8], ef);
                rd(p, 2, rv); chk("R9 dir readback", rv, dir);
                rd(p, 1, rv); chk("R9 data readback", rv, dat);
                rd(p, 3, rv); chk("R9 drive readback", rv, drv);
            end
            if (p < 3) ext_oe[p*8 +: 8] = 8'h00;
            wr(p, 2, 8'h00);
            wr(p, 3, 8'h00);
            wr(p, 1, 8'h00);
        end

        // R3: ext_oe lags by one edge (port A, pin 0, push-pull, direction 0)
        @(negedge clk);
        ext_oe[0] = 1'b1;
        #1 chk("R3 before edge", 8'(pad_oe[0]), 8'h00);
        @(negedge clk);
        chk("R3 after edge", 8'(pad_oe[0]), 8'h01);
        ext_oe[0] = 1'b0;
        @(negedge clk);
        chk("R3 release", 8'(pad_oe[0]), 8'h00);

        // R4: all external enables active, port D direction 0
        ext_oe = '1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 port D ignores enables", pad_oe[31:24], 8'h00);
        chk("R3 port C follows enables", pad_oe[23:16], 8'hFF);
        ext_oe = '0;

        // R5: port D upper bits dropped
        wr(3, 1, 8'hFF); wr(3, 2, 8'hFF); wr(3, 3, 8'hFF);
        rd(3, 1, rv); chk("R5 D data clip", rv, 8'h07);
        rd(3, 2, rv); chk("R5 D dir clip", rv, 8'h07);
        rd(3, 3, rv); chk("R5 D drive clip", rv, 8'h07);
        chk("R5 D pad_oe", pad_oe[31:24], 8'h07);
        chk("R5 D pad_out", pad_out[31:24], 8'h07);
        chk("R5 D pad_fast", pad_fast[31:24], 8'h07);

        // R10: live data-in under mixed directions, writes to data-in ignored
        wr(0, 2, 8'h3C);
        pad_in = 32'hA55A_C3E1;
        for (int p = 0; p < 4; p++) begin
            rd(p, 0, rv);
            chk("R10 data-in read", rv, pad_in[p*8 +: 8] & m_impl(p));
        end
        wr(0, 0, 8'hFF);
        rd(0, 1, rv); chk("R10 din write ignored data", rv, 8'h00);
        rd(0, 2, rv); chk("R10 din write ignored dir", rv, 8'h3C);
        rd(0, 3, rv); chk("R10 din write ignored drive", rv, 8'h00);
        chk("R10 din write pads", pad_oe[7:0], 8'h3C);
        chk("R10 din write pad_out", pad_out[7:0], 8'h00);

        // R11: address and data present without strobe
        @(negedge clk);
        bus_addr = 4'h6; bus_wdata = 8'h99;
        @(negedge clk);
        @(negedge clk);
        rd(1, 2, rv); chk("R11 no strobe no write", rv, 8'h00);
        chk("R11 no strobe pads", pad_oe[15:8], 8'h00);

        // R9: distinct value in every register, then full walk
        for (int p = 0; p < 4; p++)
            for (int r = 1; r < 4; r++)
                wr(p, r, 8'((p * 3 + r) * 17 + 1));
        for (int p = 0; p < 4; p++)
            for (int r = 1; r < 4; r++) begin
                rd(p, r, rv);
                chk("R9 map walk", rv, 8'((p * 3 + r) * 17 + 1) & m_impl(p));
            end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule